// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer configured through a single byte-wide control register. Software programs a timeout made of a 5-bit multiplier and a 2-bit resolution code. The unit of time is one pulse of the `tick` input, which the system provides at sixteen pulses per second. Every access to the control register, whether a write or a read, restarts the countdown. If software stops servicing the register, the countdown expires. The block then latches a timeout flag and does one of two things, chosen by a steering bit. It either asks the system for a reset, or it raises a single interrupt pulse.

A small byte register port gives access to three locations: the control register, a read-only flags register, and a calendar register that holds one century bit. A timeout that is steered to reset clears that century bit. The clock source and the logic that acts on the reset request are outside this block.

Top module: `wdg_top`

## Requirements
- R1: The control register (address 0) holds the steering bit in bit 7, the multiplier in bits [6:2] and the resolution code in bits [1:0]. The timeout is N = multiplier × 4^code ticks. Expiry happens on the N-th tick pulse after the restart, and its effect is visible after that clock edge.
- R2: A control value that gives N = 0 disables the watchdog. This covers the all-zero value and a zero multiplier with any resolution code. No flag is set and neither output pulses.
- R3: A write to the control register stores the value, clears the timeout flag and restarts the countdown from the new value.
- R4: A read of the control register returns the stored value, clears the timeout flag and restarts the countdown from the stored value.
- R5: On expiry, bit 7 of the flags register (address 1) is set. All other flag bits read 0.
- R6: If the steering bit is 1 at expiry, `rst_req` is high for exactly one cycle, `irq` stays low, the control register becomes 0 and the century bit is cleared.
- R7: If the steering bit is 0 at expiry, `irq` is high for exactly one cycle and `rst_req` stays low. The control register keeps its value, and no further expiry occurs until the next restart.
- R8: Writes to the flags register are ignored.
- R9: Synchronous reset clears the control register, the flag and the century bit, stops the countdown and holds both outputs low.
- R10: The calendar register (address 2) stores only bit 6, the century bit. Its other bits read 0, and address 3 reads 0.
- R11: The countdown advances only on cycles where `tick` is high. Without tick pulses an armed watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe, one per 1/16 s |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; on the control register it restarts the countdown |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench uses the block's only configuration: a 5-bit multiplier and a 2-bit code. It holds `tick` high so that one tick equals one clock. This keeps the longest timeout at 1984 cycles, which makes it practical to sweep all 128 control values. The sweep counts each expiry to the exact cycle, including every zero-multiplier value that must stay silent. Directed sequences then cover a read re-arming the countdown partway through, a timeout steered to reset with its side effects on the control and century registers, ignored writes to the flags register, a reset taken while the countdown is running, and a countdown with the tick held off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W    = 8;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int CENT_BIT  = 6;
    localparam int FLAG_BIT  = 7;
    localparam int MAX_TICKS = ((1 << MULT_W) - 1) * (1 << (2 * ((1 << RES_W) - 1)));
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdg_cfg_t;

    typedef enum logic [1:0] {
        A_CFG   = 2'd0,
        A_FLAGS = 2'd1,
        A_CENT  = 2'd2,
        A_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_addr_e addr;
        byte_t     data;
    } bus_req_t;

    function automatic cnt_t timeout_ticks(wdg_cfg_t c);
        cnt_t base;
        base = cnt_t'(c.mult);
        return base << {c.res, 1'b0};
    endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     expire,
    output wdg_cfg_t cfg_q,
    output logic     flag_q,
    output logic     cent_q,
    output logic     restart,
    output wdg_cfg_t restart_cfg,
    output byte_t    rdata
);
    logic cfg_wr, cfg_rd, cent_wr, steer_exp;

    assign cfg_wr      = req.wr && (req.addr == A_CFG);
    assign cfg_rd      = req.rd && (req.addr == A_CFG);
    assign cent_wr     = req.wr && (req.addr == A_CENT);
    assign restart     = cfg_wr || cfg_rd;
    assign restart_cfg = cfg_wr ? wdg_cfg_t'(req.data) : cfg_q;
    assign steer_exp   = expire && cfg_q.steer;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
            cent_q <= 1'b0;
        end else begin
            if (cfg_wr)
                cfg_q <= wdg_cfg_t'(req.data);
            else if (steer_exp)
                cfg_q <= '0;

            if (restart)
                flag_q <= 1'b0;
            else if (expire)
                flag_q <= 1'b1;

            if (cent_wr)
                cent_q <= req.data[CENT_BIT];
            else if (steer_exp)
                cent_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (req.addr)
            A_CFG:   rdata = byte_t'(cfg_q);
            A_FLAGS: rdata[FLAG_BIT] = flag_q;
            A_CENT:  rdata[CENT_BIT] = cent_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     restart,
    input  wdg_cfg_t load_cfg,
    output logic     expire
);
    cnt_t cnt_q;
    cnt_t load_val;
    logic armed_q;

    assign load_val = timeout_ticks(load_cfg);
    assign expire   = armed_q && tick && !restart && (cnt_q == cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart) begin
            cnt_q   <= load_val;
            armed_q <= (load_val != '0);
        end else if (tick && armed_q) begin
            cnt_q <= cnt_q - cnt_t'(1);
            if (cnt_q == cnt_t'(1))
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    output logic rst_req,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= expire && steer;
            irq     <= expire && !steer;
        end
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        rst_req,
    output logic        irq
);
    bus_req_t req;
    wdg_cfg_t cfg_q, restart_cfg;
    logic     flag_q, cent_q, restart, expire;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.addr = reg_addr_e'(bus_addr);
    assign req.data = bus_wdata;

    wdg_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .expire(expire),
        .cfg_q(cfg_q), .flag_q(flag_q), .cent_q(cent_q),
        .restart(restart), .restart_cfg(restart_cfg), .rdata(bus_rdata)
    );

    wdg_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .restart(restart),
        .load_cfg(restart_cfg), .expire(expire)
    );

    wdg_pulse u_pulse (
        .clk(clk), .rst(rst), .expire(expire), .steer(cfg_q.steer),
        .rst_req(rst_req), .irq(irq)
    );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       irq,
    input logic       rst_req,
    input logic       flag,
    input logic [7:0] cfg
);
    p_excl_r6: assert property (@(posedge clk) disable iff (rst) !(irq && rst_req));
    p_one_irq_r7: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    p_one_req_r6: assert property (@(posedge clk) disable iff (rst) rst_req |=> !rst_req);
    p_flag_irq_r5: assert property (@(posedge clk) disable iff (rst) (irq || rst_req) |-> flag);
    p_cfg_clr_r6: assert property (@(posedge clk) disable iff (rst) rst_req |-> (cfg == 8'h00));
    p_wr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> !flag);
    p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0) |=> !flag);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg == 8'h00 && !(bus_wr && bus_addr == 2'd0)) |=> !(irq || rst_req));
    p_reset_r9: assert property (@(posedge clk) rst |=> (!flag && !irq && !rst_req));
endmodule

bind wdg_top wdg_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .irq(irq), .rst_req(rst_req), .flag(flag_q), .cfg(cfg_q)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rst_req, irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int req_cnt = 0;
    logic [7:0] d;

    always #2 clk = ~clk;

    wdg_top dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq(irq)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (rst_req) req_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        cyc(3);
        rst = 1'b0;
        // R9: reset state
        peek(2'd0, d); check(d == 8'h00, "R9 cfg after reset", d, 0);
        peek(2'd1, d); check(d == 8'h00, "R9 flags after reset", d, 0);
        peek(2'd2, d); check(d == 8'h00, "R9 cent after reset", d, 0);
        check(!irq && !rst_req, "R9 outputs after reset", {irq, rst_req}, 0);

        // R1/R2/R3/R5/R7: sweep all non-steered control values
        for (int m = 0; m < 32; m++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] v;
                int n;
                v = {1'b0, 5'(m), 2'(r)};
                n = m * (1 << (2 * r));
                wr(2'd0, v);
                peek(2'd1, d); check(d == 8'h00, "R3 flag cleared by write", d, 0);
                if (n == 0) begin
                    base = irq_cnt + req_cnt;
                    cyc(40);
                    check(irq_cnt + req_cnt == base, "R2 disabled value silent", irq_cnt + req_cnt, base);
                    peek(2'd1, d); check(d == 8'h00, "R2 no flag", d, 0);
                end else begin
                    cyc(n - 1);
                    check(!irq, "R1 no early expiry", irq, 0);
                    cyc(1);
                    check(irq && !rst_req, "R1 expiry at N ticks", {irq, rst_req}, 2);
                    peek(2'd1, d); check(d == 8'h80, "R5 flag set", d, 8'h80);
                    cyc(1);
                    check(!irq, "R7 single pulse", irq, 0);
                    peek(2'd0, d); check(d == v, "R7 cfg retained", d, v);
                end
            end
        end

        // R7: no repeat without restart
        wr(2'd0, 8'h04);
        base = irq_cnt;
        cyc(60);
        check(irq_cnt == base + 1, "R7 no repeat", irq_cnt - base, 1);

        // R4: read re-arms and clears flag
        rd(2'd0, d); check(d == 8'h04, "R4 read value", d, 8'h04);
        peek(2'd1, d); check(d == 8'h00, "R4 flag cleared by read", d, 0);
        wr(2'd0, 8'h28);
        cyc(5);
        rd(2'd0, d); check(d == 8'h28, "R4 read value mid-count", d, 8'h28);
        cyc(9);
        check(!irq, "R4 restart by read delays expiry", irq, 0);
        cyc(1);
        check(irq, "R4 expiry 10 ticks after read", irq, 1);

        // R10: calendar register
        wr(2'd2, 8'hFF);
        peek(2'd2, d); check(d == 8'h40, "R10 only century bit", d, 8'h40);
        peek(2'd3, d); check(d == 8'h00, "R10 address 3 reads 0", d, 0);

        // R6: steered to reset, N = 3*4 = 12
        wr(2'd0, 8'h8D);
        cyc(11);
        check(!rst_req, "R6 no early request", rst_req, 0);
        cyc(1);
        check(rst_req && !irq, "R6 reset request", {rst_req, irq}, 2);
        peek(2'd0, d); check(d == 8'h00, "R6 cfg cleared", d, 0);
        peek(2'd2, d); check(d == 8'h00, "R6 century cleared", d, 0);
        peek(2'd1, d); check(d == 8'h80, "R6 flag set", d, 8'h80);
        cyc(1);
        check(!rst_req, "R6 single pulse", rst_req, 0);

        // R8: flags writes ignored
        wr(2'd1, 8'h00);
        peek(2'd1, d); check(d == 8'h80, "R8 write cannot clear flag", d, 8'h80);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF);
        peek(2'd1, d); check(d == 8'h00, "R8 write cannot set flag", d, 0);

        // R11: tick gating, N = 2
        tick = 1'b0;
        wr(2'd0, 8'h08);
        base = irq_cnt;
        cyc(30);
        check(irq_cnt == base, "R11 no progress without tick", irq_cnt - base, 0);
        tick = 1'b1; cyc(1); tick = 1'b0;
        check(!irq, "R11 one tick not enough", irq, 0);
        cyc(1); tick = 1'b1; cyc(1); tick = 1'b0;
        check(irq, "R11 expiry on second tick", irq, 1);
        tick = 1'b1;

        // R9: reset mid-count
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h14);
        cyc(2);
        rst = 1'b1; cyc(1); rst = 1'b0;
        base = irq_cnt + req_cnt;
        cyc(20);
        check(irq_cnt + req_cnt == base, "R9 reset stops count", irq_cnt + req_cnt - base, 0);
        peek(2'd0, d); check(d == 8'h00, "R9 cfg cleared by reset", d, 0);
        peek(2'd2, d); check(d == 8'h00, "R9 century cleared by reset", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule